// File: doc/BRIEF.md
# Multi-Buffer Receive Interrupt Controller

This block is the interrupt control register of a serial receiver that fills four receive buffers in turn. For each buffer it keeps an interrupt-enable bit and a receive-ready flag, and it raises one combined interrupt request when any buffer has both its flag and its enable set. The CPU reads and writes the register through a single-register port. The receiver pulses one strobe input when buffer 1, 2 or 3 becomes ready.

The ready flag of buffer 0 is not stored here. It belongs to a separate receiver status register and comes in as a level input. The block shows it at bit 4 of the readback, so one read tells software which buffer interrupted. CPU writes cannot change it; software clears it in its own register and the mirror follows. The flags of buffers 1 to 3 are sticky and stay set until software writes them to 0. Per-buffer interrupts apply only while the receiver runs in four-buffer mode.

The 8-bit view has this layout: bits 0 to 3 are the enables for buffers 0 to 3, bit 4 is the buffer-0 mirror, and bits 5 to 7 are the flags of buffers 1 to 3. A single reset input stands for every reset source of the chip.

Top module: `rxirq_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released, the readback is 0x01 (enable 0 set, everything else clear, with `buf0_flag_i` low) and `irq_o` is low.
- R2: A write (`wr_en_i` high at a clock edge) loads `wr_data_i[3:0]` into the enables for buffers 0 to 3, read back at bits 3:0. A 1 enables a buffer.
- R3: Readback bit 4 always equals `buf0_flag_i`. A write has no effect on it, whatever the value of `wr_data_i[4]`.
- R4: In four-buffer mode (`quad_mode_i` = 1), a high `rdy_set_i[k]` at a clock edge sets the flag of buffer k+1, read back at bit 5+k, from the next cycle on.
- R5: The flags at bits 7:5 never clear on their own. They change only through a write, which loads `wr_data_i[7:5]`, or through a strobe.
- R6: When a strobe and a write that clears the same flag arrive at the same edge, the flag is set.
- R7: In four-buffer mode, `irq_o` is high exactly when some buffer has both its flag and its enable set. The flag of buffer 0 is `buf0_flag_i`, and `irq_o` follows it in the same cycle.
- R8: With `quad_mode_i` = 0, `irq_o` is low whatever the flags and enables are.
- R9: With `quad_mode_i` = 0, the strobes are ignored and the flags keep their values unless written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, the OR of all reset sources |
| quad_mode_i | input | 1 | 1 = four-buffer receive mode |
| wr_en_i | input | 1 | CPU write strobe for the register |
| wr_data_i | input | 8 | CPU write data, in the layout of the readback |
| rdy_set_i | input | 3 | Receive-ready strobes for buffers 1..3 (bit 0 = buffer 1) |
| buf0_flag_i | input | 1 | Buffer-0 ready flag from the receiver status register |
| rd_data_o | output | 8 | Register readback |
| irq_o | output | 1 | Combined receive interrupt request |

## Verification
The hardest case to reach from the ports is a strobe and a clearing write that hit the same flag at the same edge. Only one ordering of the two can lose a receive event. The stimulus first sets a flag, then drives a write with 0 in that bit while the strobe is high in the same cycle. It repeats this with the mode off, so the bench sees the write win there instead. A long pseudo-random phase then mixes mode changes, writes, strobes and changes of the buffer-0 flag, and a reference model is compared every cycle.

// File: rtl/rxirq_pkg.sv
package rxirq_pkg;

    typedef enum logic {
        RXI_MODE_SINGLE = 1'b0,
        RXI_MODE_QUAD   = 1'b1
    } rxi_mode_e;

    // Next value of one sticky flag: a hardware set beats a software write.
    function automatic logic rxi_flag_next(input logic cur,
                                           input logic hw_set,
                                           input logic sw_wr,
                                           input logic sw_val);
        logic nxt;
        nxt = cur;
        if (sw_wr) nxt = sw_val;
        if (hw_set) nxt = 1'b1;
        return nxt;
    endfunction

endpackage

// File: rtl/rxirq_enable_reg.sv
module rxirq_enable_reg #(
    parameter int NBUF = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [NBUF-1:0] wr_val,
    output logic [NBUF-1:0] en_o
);
    localparam logic [NBUF-1:0] EN_RST = {{(NBUF-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [NBUF-1:0] en;
    } en_state_t;

    en_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) st_d.en = wr_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{en: EN_RST};
        else        st_q <= st_d;
    end

    assign en_o = st_q.en;
endmodule

// File: rtl/rxirq_flag_cell.sv
module rxirq_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_set,
    input  logic sw_wr,
    input  logic sw_val,
    output logic flag_o
);
    import rxirq_pkg::*;

    typedef struct packed {
        logic flag;
    } flag_state_t;

    flag_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.flag = rxi_flag_next(st_q.flag, hw_set, sw_wr, sw_val);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{flag: 1'b0};
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;
endmodule

// File: rtl/rxirq_req_merge.sv
module rxirq_req_merge #(
    parameter int NBUF = 4
) (
    input  logic            mode_quad,
    input  logic [NBUF-1:0] flags,
    input  logic [NBUF-1:0] enables,
    output logic            req_o
);
    logic [NBUF-1:0] hit;

    genvar g;
    generate
        for (g = 0; g < NBUF; g++) begin : g_hit
            assign hit[g] = flags[g] & enables[g];
        end
    endgenerate

    always_comb begin
        req_o = 1'b0;
        if (mode_quad) req_o = |hit;
    end
endmodule

// File: rtl/rxirq_ctrl.sv
module rxirq_ctrl #(
    parameter int NBUF = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                quad_mode_i,
    input  logic                wr_en_i,
    input  logic [2*NBUF-1:0]   wr_data_i,
    input  logic [NBUF-2:0]     rdy_set_i,
    input  logic                buf0_flag_i,
    output logic [2*NBUF-1:0]   rd_data_o,
    output logic                irq_o
);
    import rxirq_pkg::*;

    localparam int EN_LSB   = 0;
    localparam int MIR_BIT  = NBUF;
    localparam int FLG_LSB  = NBUF + 1;
    localparam int NSTICKY  = NBUF - 1;

    rxi_mode_e        mode;
    logic [NBUF-1:0]  en_q;
    logic [NSTICKY-1:0] sticky_q;
    logic [NSTICKY-1:0] set_ok;
    logic [NBUF-1:0]  all_flags;

    assign mode = quad_mode_i ? RXI_MODE_QUAD : RXI_MODE_SINGLE;

    rxirq_enable_reg #(.NBUF(NBUF)) u_en (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en_i),
        .wr_val (wr_data_i[EN_LSB +: NBUF]),
        .en_o   (en_q)
    );

    genvar g;
    generate
        for (g = 0; g < NSTICKY; g++) begin : g_flag
            assign set_ok[g] = (mode == RXI_MODE_QUAD) & rdy_set_i[g];
            rxirq_flag_cell u_cell (
                .clk    (clk),
                .rst_n  (rst_n),
                .hw_set (set_ok[g]),
                .sw_wr  (wr_en_i),
                .sw_val (wr_data_i[FLG_LSB + g]),
                .flag_o (sticky_q[g])
            );
        end
    endgenerate

    assign all_flags = {sticky_q, buf0_flag_i};

    rxirq_req_merge #(.NBUF(NBUF)) u_merge (
        .mode_quad (mode == RXI_MODE_QUAD),
        .flags     (all_flags),
        .enables   (en_q),
        .req_o     (irq_o)
    );

    always_comb begin
        rd_data_o                        = '0;
        rd_data_o[EN_LSB +: NBUF]        = en_q;
        rd_data_o[MIR_BIT]               = buf0_flag_i;
        rd_data_o[FLG_LSB +: NSTICKY]    = sticky_q;
    end
endmodule

// File: rtl/rxirq_ctrl_chk.sv
module rxirq_ctrl_chk #(
    parameter int NBUF = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              quad_mode_i,
    input logic              wr_en_i,
    input logic [2*NBUF-1:0] wr_data_i,
    input logic [NBUF-2:0]   rdy_set_i,
    input logic [2*NBUF-1:0] rd_data_o,
    input logic              irq_o
);
    localparam int FL = NBUF + 1;
    localparam int HI = 2*NBUF - 1;

    // R1: state just out of reset
    a_r1_reset_value: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (rd_data_o[NBUF-1:0] == {{(NBUF-1){1'b0}}, 1'b1}
                          && rd_data_o[HI:FL] == '0));

    // R2: a write loads the enables
    a_r2_enable_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> rd_data_o[NBUF-1:0] == $past(wr_data_i[NBUF-1:0]));

    // R4: strobes in four-buffer mode set their flags
    a_r4_strobe_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (quad_mode_i && |rdy_set_i) |=>
            ((rd_data_o[HI:FL] & $past(rdy_set_i)) == $past(rdy_set_i)));

    // R5: a flag only falls after a write of 0 to it
    genvar g;
    generate
        for (g = 0; g < NBUF-1; g++) begin : g_sticky
            a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(rd_data_o[FL+g]) |-> $past(wr_en_i && !wr_data_i[FL+g]));
        end
    endgenerate

    // R8: no request outside four-buffer mode
    a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !quad_mode_i |-> !irq_o);

    // R9: single mode without a write keeps the flags
    a_r9_single_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!quad_mode_i && !wr_en_i) |=> $stable(rd_data_o[HI:FL]));
endmodule

bind rxirq_ctrl rxirq_ctrl_chk #(.NBUF(NBUF)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .quad_mode_i (quad_mode_i),
    .wr_en_i     (wr_en_i),
    .wr_data_i   (wr_data_i),
    .rdy_set_i   (rdy_set_i),
    .rd_data_o   (rd_data_o),
    .irq_o       (irq_o)
);

// File: tb/sim_rxirq_ctrl.sv
module sim_rxirq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       quad = 1'b0;
    logic       wen = 1'b0;
    logic [7:0] wd = 8'h00;
    logic [2:0] setv = 3'b000;
    logic       b0 = 1'b0;
    logic [7:0] rd;
    logic       irq;

    int total = 0;
    int bad = 0;
    string tag = "R1";

    // reference state
    int m_en[4];
    int m_fl[4];

    always #2 clk = ~clk;

    rxirq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .quad_mode_i(quad), .wr_en_i(wen),
        .wr_data_i(wd), .rdy_set_i(setv), .buf0_flag_i(b0),
        .rd_data_o(rd), .irq_o(irq)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin
                m_en[i] = (i == 0) ? 1 : 0;
                m_fl[i] = 0;
            end
        end else begin
            if (wen) for (int i = 0; i < 4; i++) m_en[i] = wd[i];
            for (int i = 1; i < 4; i++) begin
                if (quad && setv[i-1]) m_fl[i] = 1;
                else if (wen)          m_fl[i] = wd[4+i];
            end
        end
    end

    function automatic logic [7:0] exp_rd();
        logic [7:0] v;
        for (int i = 0; i < 4; i++) v[i] = (m_en[i] != 0);
        v[4] = b0;
        for (int i = 1; i < 4; i++) v[4+i] = (m_fl[i] != 0);
        return v;
    endfunction

    function automatic logic exp_irq();
        logic r;
        r = 1'b0;
        if (quad) begin
            if (b0 && m_en[0] != 0) r = 1'b1;
            for (int i = 1; i < 4; i++)
                if (m_fl[i] != 0 && m_en[i] != 0) r = 1'b1;
        end
        return r;
    endfunction

    task automatic check_now();
        total++;
        if (rd !== exp_rd()) begin
            bad++;
            $display("FAIL %s readback: got %h expected %h", tag, rd, exp_rd());
        end
        total++;
        if (irq !== exp_irq()) begin
            bad++;
            $display("FAIL %s irq: got %b expected %b", tag, irq, exp_irq());
        end
    endtask

    // one cycle: check the outputs settled from the previous stimulus, then drive
    task automatic step(input logic q, input logic we, input logic [7:0] d,
                        input logic [2:0] s, input logic f0);
        @(negedge clk);
        check_now();
        quad = q; wen = we; wd = d; setv = s; b0 = f0;
    endtask

    initial begin
        #400000;
        bad++; total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] lf;
        // R1: reset value, with stray activity on the inputs
        tag = "R1";
        step(1, 1, 8'hFF, 3'b111, 0);
        step(1, 1, 8'hFF, 3'b111, 0);
        @(negedge clk); rst_n = 1'b1; quad = 1; wen = 0; setv = 0;
        step(1, 0, 8'h00, 3'b000, 0);
        step(1, 0, 8'h00, 3'b000, 0);
        // R2: enable writes
        tag = "R2";
        step(1, 1, 8'h0F, 3'b000, 0);
        step(1, 1, 8'h0A, 3'b000, 0);
        step(1, 1, 8'h05, 3'b000, 0);
        step(1, 0, 8'h00, 3'b000, 0);
        // R3: mirror follows input, writes to bit 4 ignored
        tag = "R3";
        step(1, 0, 8'h00, 3'b000, 1);
        step(1, 1, 8'h11, 3'b000, 1);
        step(1, 1, 8'h01, 3'b000, 1);
        step(1, 1, 8'h10, 3'b000, 0);
        step(1, 0, 8'h00, 3'b000, 0);
        // R7: buffer-0 request through mirror and enable 0
        tag = "R7";
        step(1, 1, 8'h01, 3'b000, 0);
        step(1, 0, 8'h00, 3'b000, 1);
        step(1, 0, 8'h00, 3'b000, 0);
        // R4: each strobe sets its flag
        tag = "R4";
        step(1, 0, 8'h00, 3'b001, 0);
        step(1, 0, 8'h00, 3'b010, 0);
        step(1, 0, 8'h00, 3'b100, 0);
        step(1, 0, 8'h00, 3'b000, 0);
        // R5: flags stay, cleared only by writes of 0
        tag = "R5";
        step(1, 0, 8'h00, 3'b000, 0);
        step(1, 0, 8'h00, 3'b000, 0);
        step(1, 1, 8'hA0, 3'b000, 0);
        step(1, 1, 8'h00, 3'b000, 0);
        step(1, 0, 8'h00, 3'b000, 0);
        // R6: set beats a same-cycle clear
        tag = "R6";
        step(1, 1, 8'hE0, 3'b000, 0);
        step(1, 1, 8'h00, 3'b010, 0);
        step(1, 1, 8'h00, 3'b101, 0);
        step(1, 0, 8'h00, 3'b000, 0);
        // R7: request per enabled buffer
        tag = "R7";
        step(1, 1, 8'h02, 3'b000, 0);
        step(1, 1, 8'h24, 3'b000, 0);
        step(1, 1, 8'h48, 3'b000, 0);
        step(1, 1, 8'hE0, 3'b000, 0);
        step(1, 1, 8'hEE, 3'b000, 0);
        // R8: mode off masks the request
        tag = "R8";
        step(0, 0, 8'h00, 3'b000, 1);
        step(0, 1, 8'hEF, 3'b000, 1);
        step(0, 0, 8'h00, 3'b000, 0);
        // R9: strobes ignored in single mode, writes still clear
        tag = "R9";
        step(0, 1, 8'h0F, 3'b000, 0);
        step(0, 0, 8'h00, 3'b111, 0);
        step(0, 1, 8'hA0, 3'b111, 0);
        step(0, 0, 8'h00, 3'b010, 0);
        step(0, 1, 8'h00, 3'b111, 0);
        step(0, 0, 8'h00, 3'b000, 0);
        // R7: random mix against the model
        tag = "R7";
        lf = 32'h1D2C3B4A;
        for (int n = 0; n < 600; n++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            step(lf[3] | lf[9], lf[4] & lf[11], lf[19:12], lf[27:25] & {3{lf[5]}}, lf[7]);
        end
        step(1, 0, 8'h00, 3'b000, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule